// File: doc/BRIEF.md
# Hardwired Single-Cycle Control Decoder

This block is the control unit of a single-cycle processor datapath. It is purely combinational. Each cycle it reads the 6-bit opcode, the 6-bit function field and the ALU zero flag, and it drives every datapath select and write enable:

- immediate extension mode
- ALU second-operand source
- ALU operation
- data-memory write enable
- register-file write enable
- writeback source
- destination-register select
- next-PC source

Register-to-register ALU operations, signed and unsigned immediate operations, load-high-immediate, word loads and stores, the two branches on a zero or nonzero register, absolute jumps and register-indirect jumps (each with or without link) are decoded. Opcodes the block does not recognise, and register-format words with an unknown function field, decode to a harmless no-op. A no-op writes nothing and advances the PC by four.

The datapath feeds the register operand through the ALU for a branch test. It then uses the zero flag this block receives. Only the branch opcodes let that flag influence any output.

Top module: `hw_ctl_decoder`

## Requirements
- R1: Opcode 0x00 with func 0x20/0x22/0x24/0x25/0x26/0x2A selects ALU op add=0/sub=1/and=2/or=3/xor=4/slt=5 respectively, with b_src=0 (register), reg_we=1, wb_sel=0 (ALU), dst_sel=1 (rd), pc_sel=0 (pc+4), ext_sel=0, mem_we=0.
- R2: Signed immediate opcodes 0x08 (add) and 0x0A (slt) give ext_sel=0 (sign-extend 16), b_src=1 (immediate), ALU op add=0 or slt=5, reg_we=1, wb_sel=0, dst_sel=0 (rt), pc_sel=0, mem_we=0.
- R3: Unsigned immediate opcodes 0x0C/0x0D/0x0E give ext_sel=1 (zero-extend 16), b_src=1, ALU op and=2/or=3/xor=4, reg_we=1, wb_sel=0, dst_sel=0, pc_sel=0, mem_we=0.
- R4: Opcode 0x0F (load high immediate) gives ext_sel=2 (immediate into upper 16 bits), b_src=1, ALU op pass-B=6, reg_we=1, wb_sel=0, dst_sel=0, pc_sel=0, mem_we=0.
- R5: Load opcode 0x23 gives ext_sel=0, b_src=1, ALU op add=0, reg_we=1, wb_sel=1 (memory), dst_sel=0, pc_sel=0, mem_we=0.
- R6: Store opcode 0x2B gives ext_sel=0, b_src=1, ALU op add=0, mem_we=1, reg_we=0, wb_sel=0, dst_sel=0, pc_sel=0.
- R7: Branch opcodes 0x04 (taken when zero=1) and 0x05 (taken when zero=0) give ALU op zero-test=7, ext_sel=0, b_src=0, no writes, wb_sel=0, dst_sel=0. pc_sel is 1 (branch target) when taken and 0 otherwise.
- R8: Opcode 0x02 gives pc_sel=3 (absolute target) with no writes. Opcode 0x03 does the same and also gives reg_we=1, wb_sel=2 (PC link), dst_sel=2 (R31). All other fields are 0.
- R9: Opcode 0x06 gives pc_sel=2 (register-indirect) with no writes. Opcode 0x07 does the same and also gives reg_we=1, wb_sel=2, dst_sel=2. All other fields are 0.
- R10: Every other opcode, and opcode 0x00 with any other func value, drives all outputs to 0: no register write, no memory write, pc_sel=0.
- R11: For every opcode except 0x04 and 0x05, all outputs are the same for zero=0 and zero=1.
- R12: The memory and register write enables are never both 1. A register write with wb_sel=2 always targets dst_sel=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Primary opcode field |
| func_i | input | 6 | Function field, meaningful for opcode 0 |
| zero_i | input | 1 | ALU zero flag |
| ext_sel_o | output | 2 | Immediate extension mode |
| b_src_o | output | 1 | ALU B source: 0 register, 1 immediate |
| alu_op_o | output | 3 | ALU operation code |
| mem_we_o | output | 1 | Data memory write enable |
| reg_we_o | output | 1 | Register file write enable |
| wb_sel_o | output | 2 | Writeback source: 0 ALU, 1 memory, 2 PC link |
| dst_sel_o | output | 2 | Destination: 0 rt, 1 rd, 2 R31 |
| pc_sel_o | output | 2 | Next PC: 0 pc+4, 1 branch, 2 register, 3 absolute |

## Verification
The embedded assertions assume that opcode, func and zero carry known values. They stay silent while any of those inputs is unknown, so the X state before the bench first drives them is not reported. The bench drives all three inputs to defined values from time zero and never releases them. It sweeps every one of the 8192 combinations of opcode, func and zero, and each output vector is compared against a table the bench builds from the requirements. For each non-branch opcode, the two zero-flag results are also compared with each other.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int EXT_W  = 2;
  localparam int ALU_W  = 3;
  localparam int WB_W   = 2;
  localparam int DST_W  = 2;
  localparam int PC_W   = 2;

  typedef enum logic [EXT_W-1:0] {EXT_SIGN = 2'd0, EXT_ZERO = 2'd1, EXT_HIGH = 2'd2} ext_e;
  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 3'd0, ALU_SUB = 3'd1, ALU_AND = 3'd2, ALU_OR = 3'd3,
    ALU_XOR = 3'd4, ALU_SLT = 3'd5, ALU_PASSB = 3'd6, ALU_ZTEST = 3'd7
  } alu_e;
  typedef enum logic [WB_W-1:0]  {WB_ALU = 2'd0, WB_MEM = 2'd1, WB_LINK = 2'd2} wb_e;
  typedef enum logic [DST_W-1:0] {DST_RT = 2'd0, DST_RD = 2'd1, DST_LINK = 2'd2} dst_e;
  typedef enum logic [PC_W-1:0]  {PC_SEQ = 2'd0, PC_BR = 2'd1, PC_REG = 2'd2, PC_ABS = 2'd3} pcsel_e;

  typedef enum logic [3:0] {
    CL_NOP, CL_RFMT, CL_IMM_S, CL_IMM_U, CL_IMM_HI, CL_LOAD, CL_STORE,
    CL_BR_Z, CL_BR_NZ, CL_JABS, CL_JABS_LNK, CL_JREG, CL_JREG_LNK
  } iclass_e;

  typedef struct packed {
    ext_e   ext;
    logic   b_imm;
    alu_e   alu;
    logic   mem_we;
    logic   reg_we;
    wb_e    wb;
    dst_e   dst;
  } ctl_t;
endpackage

// File: rtl/hwc_class_decode.sv
module hwc_class_decode
  import hwc_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic [OPW-1:0] opcode_i,
  output iclass_e        class_o,
  output alu_e           imm_op_o
);
  always_comb begin
    class_o  = CL_NOP;
    imm_op_o = ALU_ADD;
    case (opcode_i)
      OPW'(6'h00): class_o = CL_RFMT;
      OPW'(6'h02): class_o = CL_JABS;
      OPW'(6'h03): class_o = CL_JABS_LNK;
      OPW'(6'h04): class_o = CL_BR_Z;
      OPW'(6'h05): class_o = CL_BR_NZ;
      OPW'(6'h06): class_o = CL_JREG;
      OPW'(6'h07): class_o = CL_JREG_LNK;
      OPW'(6'h08): begin class_o = CL_IMM_S;  imm_op_o = ALU_ADD;   end
      OPW'(6'h0A): begin class_o = CL_IMM_S;  imm_op_o = ALU_SLT;   end
      OPW'(6'h0C): begin class_o = CL_IMM_U;  imm_op_o = ALU_AND;   end
      OPW'(6'h0D): begin class_o = CL_IMM_U;  imm_op_o = ALU_OR;    end
      OPW'(6'h0E): begin class_o = CL_IMM_U;  imm_op_o = ALU_XOR;   end
      OPW'(6'h0F): begin class_o = CL_IMM_HI; imm_op_o = ALU_PASSB; end
      OPW'(6'h23): class_o = CL_LOAD;
      OPW'(6'h2B): class_o = CL_STORE;
      default:     class_o = CL_NOP;
    endcase
  end
endmodule

// File: rtl/hwc_func_decode.sv
module hwc_func_decode
  import hwc_pkg::*;
#(
  parameter int FNW = FN_W
) (
  input  logic [FNW-1:0] func_i,
  output alu_e           fn_op_o,
  output logic           fn_ok_o
);
  always_comb begin
    fn_ok_o = 1'b1;
    fn_op_o = ALU_ADD;
    case (func_i)
      FNW'(6'h20): fn_op_o = ALU_ADD;
      FNW'(6'h22): fn_op_o = ALU_SUB;
      FNW'(6'h24): fn_op_o = ALU_AND;
      FNW'(6'h25): fn_op_o = ALU_OR;
      FNW'(6'h26): fn_op_o = ALU_XOR;
      FNW'(6'h2A): fn_op_o = ALU_SLT;
      default:     fn_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/hwc_ctl_table.sv
module hwc_ctl_table
  import hwc_pkg::*;
(
  input  iclass_e class_i,
  input  alu_e    fn_op_i,
  input  logic    fn_ok_i,
  input  alu_e    imm_op_i,
  output ctl_t    ctl_o
);
  always_comb begin
    ctl_o = '{ext: EXT_SIGN, b_imm: 1'b0, alu: ALU_ADD, mem_we: 1'b0,
              reg_we: 1'b0, wb: WB_ALU, dst: DST_RT};
    case (class_i)
      CL_RFMT: if (fn_ok_i) begin
        ctl_o.alu    = fn_op_i;
        ctl_o.reg_we = 1'b1;
        ctl_o.dst    = DST_RD;
      end
      CL_IMM_S, CL_IMM_U, CL_IMM_HI: begin
        ctl_o.ext    = (class_i == CL_IMM_U)  ? EXT_ZERO :
                       (class_i == CL_IMM_HI) ? EXT_HIGH : EXT_SIGN;
        ctl_o.b_imm  = 1'b1;
        ctl_o.alu    = imm_op_i;
        ctl_o.reg_we = 1'b1;
      end
      CL_LOAD: begin
        ctl_o.b_imm  = 1'b1;
        ctl_o.reg_we = 1'b1;
        ctl_o.wb     = WB_MEM;
      end
      CL_STORE: begin
        ctl_o.b_imm  = 1'b1;
        ctl_o.mem_we = 1'b1;
      end
      CL_BR_Z, CL_BR_NZ: ctl_o.alu = ALU_ZTEST;
      CL_JABS_LNK, CL_JREG_LNK: begin
        ctl_o.reg_we = 1'b1;
        ctl_o.wb     = WB_LINK;
        ctl_o.dst    = DST_LINK;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hwc_pc_select.sv
module hwc_pc_select
  import hwc_pkg::*;
(
  input  iclass_e class_i,
  input  logic    zero_i,
  output pcsel_e  pc_sel_o
);
  always_comb begin
    case (class_i)
      CL_BR_Z:                  pc_sel_o = zero_i  ? PC_BR : PC_SEQ;
      CL_BR_NZ:                 pc_sel_o = !zero_i ? PC_BR : PC_SEQ;
      CL_JABS, CL_JABS_LNK:     pc_sel_o = PC_ABS;
      CL_JREG, CL_JREG_LNK:     pc_sel_o = PC_REG;
      default:                  pc_sel_o = PC_SEQ;
    endcase
  end
endmodule

// File: rtl/hw_ctl_decoder.sv
module hw_ctl_decoder
  import hwc_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int FNW = FN_W
) (
  input  logic [OPW-1:0]   opcode_i,
  input  logic [FNW-1:0]   func_i,
  input  logic             zero_i,
  output logic [EXT_W-1:0] ext_sel_o,
  output logic             b_src_o,
  output logic [ALU_W-1:0] alu_op_o,
  output logic             mem_we_o,
  output logic             reg_we_o,
  output logic [WB_W-1:0]  wb_sel_o,
  output logic [DST_W-1:0] dst_sel_o,
  output logic [PC_W-1:0]  pc_sel_o
);
  iclass_e icls;
  alu_e    imm_op;
  alu_e    fn_op;
  logic    fn_ok;
  ctl_t    ctl;
  pcsel_e  pc_sel;

  hwc_class_decode #(.OPW(OPW)) u_class (
    .opcode_i (opcode_i), .class_o (icls), .imm_op_o (imm_op)
  );

  hwc_func_decode #(.FNW(FNW)) u_func (
    .func_i (func_i), .fn_op_o (fn_op), .fn_ok_o (fn_ok)
  );

  hwc_ctl_table u_table (
    .class_i (icls), .fn_op_i (fn_op), .fn_ok_i (fn_ok),
    .imm_op_i (imm_op), .ctl_o (ctl)
  );

  hwc_pc_select u_pc (
    .class_i (icls), .zero_i (zero_i), .pc_sel_o (pc_sel)
  );

  assign ext_sel_o = ctl.ext;
  assign b_src_o   = ctl.b_imm;
  assign alu_op_o  = ctl.alu;
  assign mem_we_o  = ctl.mem_we;
  assign reg_we_o  = ctl.reg_we;
  assign wb_sel_o  = ctl.wb;
  assign dst_sel_o = ctl.dst;
  assign pc_sel_o  = pc_sel;

  always_comb begin
    if (!$isunknown({opcode_i, func_i, zero_i})) begin
      AST_SINGLE_WRITE: assert (!(mem_we_o && reg_we_o)); // R12
      AST_LINK_TO_R31: assert (!(reg_we_o && wb_sel_o == WB_LINK) || dst_sel_o == DST_LINK); // R12
      AST_MEM_WB_ADDR: assert (wb_sel_o != WB_MEM || (alu_op_o == ALU_ADD && b_src_o)); // R5
      AST_BRANCH_NO_WRITE: assert (pc_sel_o != PC_BR || (!reg_we_o && !mem_we_o)); // R7
      AST_ZEXT_IMM_B: assert (ext_sel_o != EXT_ZERO || b_src_o); // R3
      AST_REDIRECT_KEEPS_ALU: assert (!(pc_sel_o == PC_ABS || pc_sel_o == PC_REG) || alu_op_o == ALU_ADD); // R8
    end
  end
endmodule

// File: tb/hw_ctl_decoder_tb_top.sv
module hw_ctl_decoder_tb_top;
  logic       clk = 1'b0;
  logic [5:0] opcode;
  logic [5:0] func;
  logic       zero;
  logic [1:0] ext_sel, wb_sel, dst_sel, pc_sel;
  logic [2:0] alu_op;
  logic       b_src, mem_we, reg_we;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  hw_ctl_decoder dut_i (
    .opcode_i (opcode), .func_i (func), .zero_i (zero),
    .ext_sel_o (ext_sel), .b_src_o (b_src), .alu_op_o (alu_op),
    .mem_we_o (mem_we), .reg_we_o (reg_we), .wb_sel_o (wb_sel),
    .dst_sel_o (dst_sel), .pc_sel_o (pc_sel)
  );

  // packed order: ext(2) b(1) alu(3) mem(1) reg(1) wb(2) dst(2) pc(2)
  function automatic logic [13:0] pack(input int e, input int b, input int a, input int m,
                                       input int r, input int w, input int d, input int p);
    return {e[1:0], b[0], a[2:0], m[0], r[0], w[1:0], d[1:0], p[1:0]};
  endfunction

  function automatic logic [13:0] model(input int op, input int fn, input int z);
    int a;
    a = -1;
    if (fn == 32) a = 0; else if (fn == 34) a = 1; else if (fn == 36) a = 2;
    else if (fn == 37) a = 3; else if (fn == 38) a = 4; else if (fn == 42) a = 5;
    if (op == 0)  return (a < 0) ? 14'd0 : pack(0, 0, a, 0, 1, 0, 1, 0);
    if (op == 8)  return pack(0, 1, 0, 0, 1, 0, 0, 0);
    if (op == 10) return pack(0, 1, 5, 0, 1, 0, 0, 0);
    if (op >= 12 && op <= 14) return pack(1, 1, op - 10, 0, 1, 0, 0, 0);
    if (op == 15) return pack(2, 1, 6, 0, 1, 0, 0, 0);
    if (op == 35) return pack(0, 1, 0, 0, 1, 1, 0, 0);
    if (op == 43) return pack(0, 1, 0, 1, 0, 0, 0, 0);
    if (op == 4)  return pack(0, 0, 7, 0, 0, 0, 0, (z == 1) ? 1 : 0);
    if (op == 5)  return pack(0, 0, 7, 0, 0, 0, 0, (z == 0) ? 1 : 0);
    if (op == 2)  return pack(0, 0, 0, 0, 0, 0, 0, 3);
    if (op == 3)  return pack(0, 0, 0, 0, 1, 2, 2, 3);
    if (op == 6)  return pack(0, 0, 0, 0, 0, 0, 0, 2);
    if (op == 7)  return pack(0, 0, 0, 0, 1, 2, 2, 2);
    return 14'd0;
  endfunction

  function automatic string tag(input int op, input int fn);
    if (op == 0) return (fn == 32 || fn == 34 || fn == 36 || fn == 37 || fn == 38 || fn == 42) ? "R1" : "R10";
    if (op == 8 || op == 10) return "R2";
    if (op >= 12 && op <= 14) return "R3";
    if (op == 15) return "R4";
    if (op == 35) return "R5";
    if (op == 43) return "R6";
    if (op == 4 || op == 5) return "R7";
    if (op == 2 || op == 3) return "R8";
    if (op == 6 || op == 7) return "R9";
    return "R10";
  endfunction

  function automatic logic [13:0] observed();
    return {ext_sel, b_src, alu_op, mem_we, reg_we, wb_sel, dst_sel, pc_sel};
  endfunction

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp,
                       input int op, input int fn, input int z);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%02h fn=%02h z=%0d actual=%04h expected=%04h", req, op, fn, z, act, exp);
    end
  endtask

  initial begin
    logic [13:0] v0;
    logic [13:0] v1;
    opcode = 6'h00; func = 6'h00; zero = 1'b0;
    @(negedge clk);
    check("R10", observed(), 14'd0, 0, 0, 0);   // idle state: all fields 0
    for (int op = 0; op < 64; op++) begin
      for (int fn = 0; fn < 64; fn++) begin
        v0 = '0;
        v1 = '0;
        for (int z = 0; z < 2; z++) begin
          @(posedge clk);
          opcode = 6'(op); func = 6'(fn); zero = z[0];
          @(negedge clk);
          if (z == 0) v0 = observed(); else v1 = observed();
          check(tag(op, fn), observed(), model(op, fn, z), op, fn, z);
          if (!$isunknown({mem_we, reg_we}) && mem_we && reg_we)
            check("R12", 14'd1, 14'd0, op, fn, z);
        end
        if (op != 4 && op != 5) check("R11", v1, v0, op, fn, 1);
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule